// File: doc/BRIEF.md
# Codec Serial Frame-Sync Slave Port

This block is the serial side of an audio codec port when the codec is the timing master. The codec drives the bit clock and the frame-sync line. The port watches frame sync and decides when a frame begins, using one of three start rules. It then shifts a set number of words out on the serial output and in from the serial input, MSB first. Transmit words come in on a parallel bus and are paced by a request strobe. Received words leave on a parallel bus with a one-cycle valid strobe.

Each word is right-justified in a 20-bit parallel word. Only the low N bits are shifted, where N is the current word length. While a frame is in flight, new sync events are ignored. The port therefore always completes the frame it started. A sync event seen on the edge that captures the last bit of a frame starts the next frame at once, so frames can run back to back.

Top module: `codec_sync_slave`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sdo` is low, `rx_valid` and `tx_req` are low, and reset clears `rx_word` to zero.
- R2: In multichannel mode (`mode` = 0), a frame starts when `fsync` is high at a rising `bclk` edge. The MSB of word 0 appears on `sdo` from the next falling edge. The first `sdi` bit is taken at the following rising edge.
- R3: In I2S mode (`mode` = 1), a frame starts when the `fsync` level sampled at a rising edge differs from the level sampled one edge earlier. A change in either direction counts. Bit timing after the start matches R2.
- R4: In AC-link mode (`mode` = 2), a frame starts when `fsync` is sampled high. The frame has 13 slots: slot 0 is 16 bits and slots 1 to 12 are 20 bits each, 256 bits in all. The word-size and word-count inputs are ignored in this mode.
- R5: In the other modes, each word is `word_bits_m1`+1 bits long, and any value below 3 is treated as 3 (4 bits). A frame holds `words_m1`+1 words. Bits are sent and taken MSB first. Word bits are the low bits of `tx_word` and `rx_word`, and the unused upper bits of `rx_word` read zero.
- R6: `rx_valid` is high for exactly one cycle, the cycle after the rising edge that captures a word's last bit. In that same cycle `rx_word` holds the word.
- R7: `tx_word` is latched on the rising edge that starts a frame, and on the edge that captures the last bit of each word that is not the last in its frame. `tx_req` is high for the one cycle after each latch, so the source can present the next word.
- R8: While a frame is in progress, `fsync` events are ignored until the frame's last bit is captured. A sync event sampled on that last-bit edge starts a new frame with no idle cycle.
- R9: `mode` = 3 behaves exactly as multichannel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 multichannel, 1 I2S, 2 AC-link, 3 multichannel |
| word_bits_m1 | input | 4 | Word length minus one (non-AC-link modes) |
| words_m1 | input | 4 | Words per frame minus one (non-AC-link modes) |
| fsync | input | 1 | Frame sync from the codec |
| sdi | input | 1 | Serial data from the codec |
| tx_word | input | 20 | Next transmit word, right-justified |
| sdo | output | 1 | Serial data to the codec, changes on falling edges |
| tx_req | output | 1 | One-cycle pulse after `tx_word` has been latched |
| rx_word | output | 20 | Last received word, right-justified |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_word` |

## Verification
If the bit counter is off by one, every word boundary moves. The first `rx_valid` then arrives a cycle early or late, carrying a shifted value, within one word time of the frame start. At the same moment, `sdo` repeats or skips a bit. A broken lockout restarts the frame from word 0. The next `sdo` bit then becomes an MSB again, `tx_req` fires in the middle of a word, and extra `rx_valid` pulses follow the expected end of the frame. An active flag that stays set after the frame shows up as a non-idle `sdo` or a stray strobe during the idle cycles the bench runs after every frame that is not chained.

// File: rtl/codec_sync_slave.sv
module codec_sync_slave #(
  parameter int DW        = 20,
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int AC_SLOTS  = 13,
  parameter int MIN_BITS  = 4
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [3:0]    word_bits_m1,
  input  logic [3:0]    words_m1,
  input  logic          fsync,
  input  logic          sdi,
  input  logic [DW-1:0] tx_word,
  output logic          sdo,
  output logic          tx_req,
  output logic [DW-1:0] rx_word,
  output logic          rx_valid
);
  localparam int BW = $clog2(DW);
  localparam int SW = (AC_SLOTS > 16) ? $clog2(AC_SLOTS) : 4;
  localparam logic [1:0] M_I2S = 2'd1;
  localparam logic [1:0] M_AC  = 2'd2;

  logic          fs_q, active;
  logic [BW-1:0] bit_cnt, wlen_m1;
  logic [SW-1:0] slot_cnt, last_slot;
  logic [DW-1:0] tx_sh, rx_sh, rx_word_q;
  logic          sdo_q, tx_req_q, rx_valid_q;
  logic          is_ac, sync_hit, word_end, frame_end, start, load;

  assign is_ac = (mode == M_AC);

  always_comb begin
    if (is_ac)
      wlen_m1 = (slot_cnt == '0) ? BW'(TAG_BITS - 1) : BW'(SLOT_BITS - 1);
    else if (BW'(word_bits_m1) < BW'(MIN_BITS - 1))
      wlen_m1 = BW'(MIN_BITS - 1);
    else
      wlen_m1 = BW'(word_bits_m1);
  end

  assign last_slot = is_ac ? SW'(AC_SLOTS - 1) : SW'(words_m1);
  assign sync_hit  = (mode == M_I2S) ? (fsync ^ fs_q) : fsync;
  assign word_end  = active && (bit_cnt == wlen_m1);
  assign frame_end = word_end && (slot_cnt == last_slot);
  assign start     = sync_hit && (!active || frame_end);
  assign load      = start || (word_end && !frame_end);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q       <= 1'b0;
      active     <= 1'b0;
      bit_cnt    <= '0;
      slot_cnt   <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_word_q  <= '0;
      tx_req_q   <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      fs_q       <= fsync;
      tx_req_q   <= load;
      rx_valid_q <= word_end;
      if (word_end)
        rx_word_q <= {rx_sh[DW-2:0], sdi};
      if (start) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        slot_cnt <= '0;
        rx_sh    <= '0;
        tx_sh    <= tx_word;
      end else if (word_end) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        if (frame_end) begin
          active   <= 1'b0;
          slot_cnt <= '0;
        end else begin
          slot_cnt <= slot_cnt + 1'b1;
          tx_sh    <= tx_word;
        end
      end else if (active) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= {rx_sh[DW-2:0], sdi};
        tx_sh   <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sdo_q <= 1'b0;
    else        sdo_q <= active & tx_sh[wlen_m1];
  end

  assign sdo      = sdo_q;
  assign tx_req   = tx_req_q;
  assign rx_word  = rx_word_q;
  assign rx_valid = rx_valid_q;
endmodule

// File: rtl/codec_sync_slave_chk.sv
module codec_sync_slave_chk #(
  parameter int BW = 5,
  parameter int SW = 4
) (
  input logic          bclk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          sdo,
  input logic          tx_req,
  input logic          rx_valid,
  input logic          active,
  input logic          frame_end,
  input logic [BW-1:0] bit_cnt,
  input logic [SW-1:0] slot_cnt
);
  // R1
  idle_sdo_low_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !active |-> !sdo);
  // R1
  idle_counters_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !active |-> (bit_cnt == '0 && slot_cnt == '0));
  // R6
  rx_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6
  rx_from_frame_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |-> $past(active));
  // R7
  tx_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_req |=> !tx_req);
  // R4
  ac_slot_range_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (active && mode == 2'd2) |-> (slot_cnt <= SW'(12)));
  // R8
  lockout_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (active && !frame_end) |=> active);
endmodule

bind codec_sync_slave codec_sync_slave_chk #(.BW(BW), .SW(SW)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .mode(mode), .sdo(sdo), .tx_req(tx_req),
  .rx_valid(rx_valid), .active(active), .frame_end(frame_end),
  .bit_cnt(bit_cnt), .slot_cnt(slot_cnt)
);

// File: tb/tb_codec_sync_slave.sv
`timescale 1ns/1ps
module tb_codec_sync_slave;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  word_bits_m1 = 4'd7;
  logic [3:0]  words_m1 = 4'd0;
  logic        fsync = 1'b0;
  logic        sdi = 1'b0;
  logic [19:0] tx_word = '0;
  logic        sdo, tx_req, rx_valid;
  logic [19:0] rx_word;

  int          n_run = 0;
  int          n_fail = 0;
  logic        pend = 1'b0;
  logic [19:0] pend_word = '0;
  int          fid = 0;

  always #4 bclk = ~bclk;

  codec_sync_slave dut (
    .bclk(bclk), .rst_n(rst_n), .mode(mode), .word_bits_m1(word_bits_m1),
    .words_m1(words_m1), .fsync(fsync), .sdi(sdi), .tx_word(tx_word),
    .sdo(sdo), .tx_req(tx_req), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  function automatic logic [19:0] txval(int f, int w);
    return 20'(f * 7919 + w * 613 + 12345) ^ 20'(w << 11);
  endfunction

  function automatic logic [19:0] rxval(int f, int w);
    return 20'(f * 4099 + w * 2741 + 777) ^ 20'hA5C3;
  endfunction

  function automatic int wlen(int m, int wb, int w);
    if (m == 2) return (w == 0) ? 16 : 20;
    return ((wb < 3) ? 3 : wb) + 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge bclk);
    #1;
    chk("R6 rx_valid", 32'(rx_valid), 32'(pend));
    if (pend) chk("R6 rx_word", 32'(rx_word), 32'(pend_word));
    pend = 1'b0;
  endtask

  task automatic idle_ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      chk("R8 idle sdo", 32'(sdo), 32'd0);
      chk("R8 idle tx_req", 32'(tx_req), 32'd0);
    end
  endtask

  task automatic run_frame(int m, int wb, int nw, bit started, bit chain,
                           int glitch, string tag);
    int nwords, total, i;
    nwords = (m == 2) ? 13 : nw + 1;
    total = 0;
    for (int w = 0; w < nwords; w++) total += wlen(m, wb, w);
    if (!started) begin
      tick();
      chk("R1 idle sdo", 32'(sdo), 32'd0);
      chk("R1 idle tx_req", 32'(tx_req), 32'd0);
      mode = 2'(m);
      word_bits_m1 = 4'(wb);
      words_m1 = 4'(nw);
      fsync = (m == 1) ? ~fsync : 1'b1;
    end
    i = 0;
    for (int w = 0; w < nwords; w++) begin
      for (int j = 0; j < wlen(m, wb, w); j++) begin
        logic [19:0] tw, rw;
        int n;
        n = wlen(m, wb, w);
        tw = txval(fid, w);
        rw = rxval(fid, w);
        tick();
        if (m == 1) begin
          if (i == glitch || i == glitch + 1 || (chain && i == total - 1))
            fsync = ~fsync;
        end else begin
          fsync = (i == glitch) || (chain && i == total - 1);
        end
        chk("R7 tx_req", 32'(tx_req), 32'(j == 0));
        if (tx_req)
          tx_word = (w + 1 < nwords) ? txval(fid, w + 1) : txval(fid + 1, 0);
        chk(tag, 32'(sdo), 32'(tw[n-1-j]));
        sdi = rw[n-1-j];
        if (j == n - 1) begin
          pend = 1'b1;
          pend_word = rw & ((20'd1 << n) - 20'd1);
        end
        i++;
      end
    end
    fid++;
    if (!chain) idle_ticks(3);
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tx_word = txval(0, 0);
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    tick();
    chk("R1 reset sdo", 32'(sdo), 32'd0);
    chk("R1 reset tx_req", 32'(tx_req), 32'd0);
    chk("R1 reset rx_word", 32'(rx_word), 32'd0);
    // R2 / R5: sweep word length and word count in multichannel mode
    for (int wb = 3; wb < 16; wb++)
      for (int nw = 0; nw < 4; nw++)
        run_frame(0, wb, nw, 1'b0, 1'b0, -1, (nw == 0) ? "R2 sdo" : "R5 sdo");
    // R5: short word sizes clamp to 4 bits
    run_frame(0, 0, 2, 1'b0, 1'b0, -1, "R5 clamp sdo");
    run_frame(0, 2, 1, 1'b0, 1'b0, -1, "R5 clamp sdo");
    // R8: sync pulse mid-frame ignored; back-to-back chaining
    run_frame(0, 7, 1, 1'b0, 1'b0, 5, "R8 lockout sdo");
    run_frame(0, 4, 2, 1'b0, 1'b1, 3, "R8 chain sdo");
    run_frame(0, 4, 2, 1'b1, 1'b0, -1, "R8 chain sdo");
    // R3: either edge starts in I2S mode; mid-frame edges ignored
    run_frame(1, 15, 0, 1'b0, 1'b1, -1, "R3 sdo");
    run_frame(1, 15, 0, 1'b1, 1'b0, 3, "R3 sdo");
    run_frame(1, 7, 1, 1'b0, 1'b0, -1, "R3 sdo");
    run_frame(1, 7, 1, 1'b0, 1'b0, 9, "R3 sdo");
    // R4: AC-link 16 + 12 x 20 frame, config fields ignored
    run_frame(2, 3, 0, 1'b0, 1'b0, 100, "R4 sdo");
    run_frame(2, 9, 5, 1'b0, 1'b0, -1, "R4 sdo");
    // R9: mode 3 as multichannel
    run_frame(3, 5, 2, 1'b0, 1'b0, -1, "R9 sdo");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule